// File: doc/BRIEF.md
# I2C Frame Shifter with Bit Counter

This block is the bit-level data path of a two-wire serial port. It moves one frame of data bits in or out on the SDA line, paced by edges of an externally generated SCL, and counts the bits with a small counter whose programmed code sets the frame length from one to eight data bits. An acknowledge mode adds one extra clock to every frame. In transmit, the slot is left free for the far end to answer. In receive, the block answers in that slot itself.

Software controls the block through a small register port: a control register (enable, direction, acknowledge/serial mode, no-acknowledge answer), a length register holding the bit-count code, and a data register that is loaded before a transmit frame and read after a receive frame. SCL and SDA arrive as already synchronized levels, and SDA is driven only through an open-drain enable. An external start-condition detector resets the counter, and a one-clock pulse marks the end of each frame. Arbitration, SCL generation and the protocol sequencer are outside this block.

Top module: `i2c_frame_shifter`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00, the length register (address 1) reads 0xF8, and sda_oe is 0. A read returns data one clock after the address is presented.
- R2: Bits 7 to 3 of the length register always read as 1, whatever value is written to them.
- R3: A write to the length register whose low three bits are nonzero takes effect only while scl_in is low. A write of code 0 takes effect at any SCL level.
- R4: Length code 0 gives 8 data bits, and codes 1 to 7 give that many bits. In transmit (control bit 1 = 1), data register bits go out MSB first, each stable for the whole SCL high phase. sda_oe only changes while SCL is low or while the block is disabled.
- R5: Control bit 2 = 1 selects serial mode, with no acknowledge clock. Control bit 2 = 0 selects acknowledge mode, which adds one clock after the data bits.
- R6: On each rising SCL of a data bit, the data register (address 2) shifts left by one and SDA enters at bit 0. This holds in both directions.
- R7: In transmit acknowledge mode, SDA is released during the acknowledge clock, and the level sampled on its rising edge is readable at control bit 4.
- R8: In receive acknowledge mode (control bit 1 = 0), SDA is pulled low during the acknowledge clock unless control bit 3 (no-acknowledge) is 1.
- R9: On the rising SCL of the final clock of a frame, frame_done pulses for exactly one clock and the length code returns to 0.
- R10: Busy (control bit 5) rises with the first data bit of a frame and clears when the frame completes.
- R11: A start_det pulse clears the length code, the bit position and busy.
- R12: With control bit 0 = 0, the block never drives SDA and ignores SCL edges: there is no shift and no frame_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 length, 2 data |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| start_det | input | 1 | Start-condition detected pulse |
| sda_oe | output | 1 | SDA open-drain pull-low enable |
| frame_done | output | 1 | One-clock end-of-frame pulse |

## Verification
Register reads are registered, so the bench presents an address on one falling clock edge and samples the result on the next. An SCL rise is detected at the first clock edge that sees the high level, so shifting, the acknowledge capture, busy and frame_done all settle in that same clock. The sda_oe output follows the data one clock after SCL is seen low. The bench therefore holds each SCL phase for four clocks, samples the line at the first and third clocks of the high phase, and checks counters and registers only after SCL has returned low.

// File: rtl/i2cfs_pkg.sv
package i2cfs_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LEN  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

  // control fields, LSB first: enable, transmit, serial (no ack), answer nack
  typedef struct packed {
    logic nack;
    logic serial;
    logic tx;
    logic en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/i2cfs_edge.sv
module i2cfs_edge (
  input  logic clk,
  input  logic rst,
  input  logic line,
  output logic rise
);
  logic line_q;

  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b1;
    else     line_q <= line;
  end

  assign rise = line & ~line_q;
endmodule

// File: rtl/i2cfs_regs.sv
module i2cfs_regs
  import i2cfs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              scl_in,
  input  logic              len_clear,
  input  logic              busy,
  input  logic              ack_seen,
  input  logic [DATA_W-1:0] data_q,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  len_code,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              data_load
);
  localparam int PAD_W  = DATA_W - CNT_W;
  localparam int STAT_W = DATA_W - CTRL_W - 2;

  logic len_ok;

  assign len_ok    = (reg_wdata[CNT_W-1:0] == '0) || !scl_in;
  assign data_load = reg_we && (reg_addr == ADDR_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      len_code <= '0;
    end else begin
      if (reg_we && reg_addr == ADDR_CTRL)
        ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (len_clear)
        len_code <= '0;
      else if (reg_we && reg_addr == ADDR_LEN && len_ok)
        len_code <= reg_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        ADDR_CTRL: reg_rdata <= {{STAT_W{1'b0}}, busy, ack_seen, ctrl};
        ADDR_LEN:  reg_rdata <= {{PAD_W{1'b1}}, len_code};
        ADDR_DATA: reg_rdata <= data_q;
        default:   reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/i2cfs_shift.sv
module i2cfs_shift
  import i2cfs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [CNT_W-1:0]  len_code,
  input  logic              scl_in,
  input  logic              scl_rise,
  input  logic              sda_in,
  input  logic              start_det,
  input  logic              data_load,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] data_q,
  output logic              busy,
  output logic              ack_seen,
  output logic              frame_end,
  output logic              frame_done,
  output logic              sda_oe
);
  localparam int POS_W = CNT_W + 1;

  logic [POS_W-1:0] pos, ndata, last_pos;
  logic armed, in_data, in_ack, want_low;

  always_comb begin
    ndata     = (len_code == '0) ? POS_W'(DATA_W) : {1'b0, len_code};
    last_pos  = ctrl.serial ? ndata - POS_W'(1) : ndata;
    in_data   = pos < ndata;
    in_ack    = !ctrl.serial && (pos == ndata);
    frame_end = ctrl.en && scl_rise && !start_det && (pos == last_pos);
    want_low  = ctrl.tx ? (armed && in_data && !data_q[DATA_W-1])
                        : (in_ack && !ctrl.nack);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos        <= '0;
      data_q     <= '0;
      busy       <= 1'b0;
      armed      <= 1'b0;
      ack_seen   <= 1'b0;
      frame_done <= 1'b0;
      sda_oe     <= 1'b0;
    end else begin
      frame_done <= frame_end;
      if (!ctrl.en || start_det) begin
        pos  <= '0;
        busy <= 1'b0;
      end else if (scl_rise) begin
        if (in_data) begin
          data_q <= {data_q[DATA_W-2:0], sda_in};
          busy   <= 1'b1;
        end else if (ctrl.tx) begin
          ack_seen <= sda_in;
        end
        if (frame_end) begin
          pos   <= '0;
          busy  <= 1'b0;
          armed <= 1'b0;
        end else begin
          pos <= pos + POS_W'(1);
        end
      end
      if (data_load) begin
        data_q <= load_val;
        armed  <= 1'b1;
      end
      if (!ctrl.en)     sda_oe <= 1'b0;
      else if (!scl_in) sda_oe <= want_low;
    end
  end
endmodule

// File: rtl/i2c_frame_shifter.sv
module i2c_frame_shifter
  import i2cfs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              start_det,
  output logic              sda_oe,
  output logic              frame_done
);
  localparam int CNT_W = $clog2(DATA_W);

  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  len_code;
  logic [DATA_W-1:0] data_q;
  logic scl_rise, busy, ack_seen, frame_end, data_load, ctrl_en;

  assign ctrl_en = ctrl_q.en;

  i2cfs_edge u_scl_edge (
    .clk  (clk),
    .rst  (rst),
    .line (scl_in),
    .rise (scl_rise)
  );

  i2cfs_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .scl_in    (scl_in),
    .len_clear (frame_end | start_det),
    .busy      (busy),
    .ack_seen  (ack_seen),
    .data_q    (data_q),
    .ctrl      (ctrl_q),
    .len_code  (len_code),
    .reg_rdata (reg_rdata),
    .data_load (data_load)
  );

  i2cfs_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl_q),
    .len_code   (len_code),
    .scl_in     (scl_in),
    .scl_rise   (scl_rise),
    .sda_in     (sda_in),
    .start_det  (start_det),
    .data_load  (data_load),
    .load_val   (reg_wdata),
    .data_q     (data_q),
    .busy       (busy),
    .ack_seen   (ack_seen),
    .frame_end  (frame_end),
    .frame_done (frame_done),
    .sda_oe     (sda_oe)
  );
endmodule

// File: rtl/i2cfs_checker.sv
module i2cfs_checker #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             ctrl_en,
  input logic [CNT_W-1:0] len_code,
  input logic             busy,
  input logic             scl_in,
  input logic             start_det,
  input logic             sda_oe,
  input logic             frame_done
);
  assert_off_no_drive_R12: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |=> !sda_oe);

  assert_sda_moves_low_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> (!$past(scl_in) || !$past(ctrl_en)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  assert_len_cleared_R9: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (len_code == '0));

  assert_start_clears_R11: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (len_code == '0 && !busy));

  assert_busy_drop_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (frame_done || $past(start_det) || !$past(ctrl_en)));
endmodule

bind i2c_frame_shifter i2cfs_checker #(.CNT_W(CNT_W)) u_checker (
  .clk        (clk),
  .rst        (rst),
  .ctrl_en    (ctrl_en),
  .len_code   (len_code),
  .busy       (busy),
  .scl_in     (scl_in),
  .start_det  (start_det),
  .sda_oe     (sda_oe),
  .frame_done (frame_done)
);

// File: tb/test_i2c_frame_shifter.sv
module test_i2c_frame_shifter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic scl = 1'b1;
  logic bsda = 1'b1;
  logic start_det = 1'b0;
  logic sda_oe, frame_done;
  wire  sda_line = bsda & ~sda_oe;

  int n_chk = 0, n_fail = 0, done_cnt = 0, cyc = 0;

  always #10 clk = ~clk;

  i2c_frame_shifter i_i2c_frame_shifter (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_in(scl),
    .sda_in(sda_line), .start_det(start_det), .sda_oe(sda_oe),
    .frame_done(frame_done));

  always @(negedge clk) if (!rst && frame_done) done_cnt++;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  // one SCL clock: low phase 4 clocks, high phase 4 clocks, two line samples
  task automatic clock_bit(input logic drv, output logic s1, output logic s2);
    @(negedge clk); scl = 1'b0; bsda = drv;
    repeat (3) @(negedge clk);
    scl = 1'b1;
    @(negedge clk); s1 = sda_line;
    repeat (2) @(negedge clk); s2 = sda_line;
    @(negedge clk);
  endtask

  task automatic go_low();
    @(negedge clk); scl = 1'b0; bsda = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic int nbits(input logic [2:0] code);
    return (code == 3'd0) ? 8 : int'(code);
  endfunction

  function automatic logic [7:0] rot(input logic [7:0] d, input int n);
    return (n == 8) ? d : 8'((d << n) | (d >> (8 - n)));
  endfunction

  task automatic run_tx(input logic [7:0] d, input logic [2:0] code,
                        input logic ackm, input logic ackl);
    logic s1, s2; logic [7:0] v; int d0, n;
    go_low();
    wr(2'd0, {4'b0, 1'b0, ~ackm, 1'b1, 1'b1});
    wr(2'd1, {5'b0, code});
    wr(2'd2, d);
    n = nbits(code); d0 = done_cnt;
    for (int i = 0; i < n; i++) begin
      clock_bit(1'b1, s1, s2);
      check("R4 tx bit stable high", int'({s1, s2}), int'({2{d[7-i]}}));
    end
    if (ackm) begin
      clock_bit(ackl, s1, s2);
      check("R7 ack slot released", int'(s2), int'(ackl));
    end
    go_low();
    check("R9 R5 one done per frame", done_cnt - d0, 1);
    rd(2'd1, v); check("R9 length back to 0", v, 8'hF8);
    if (ackm) begin rd(2'd0, v); check("R7 ack level stored", v[4], ackl); end
    rd(2'd2, v); check("R6 tx shifts line in", v, rot(d, n));
  endtask

  task automatic run_rx(input logic [7:0] bits, input logic [7:0] init,
                        input logic [2:0] code, input logic ackm, input logic nack);
    logic s1, s2; logic [7:0] v, exp; int d0, n;
    go_low();
    wr(2'd0, {4'b0, nack, ~ackm, 1'b0, 1'b1});
    wr(2'd1, {5'b0, code});
    wr(2'd2, init);
    n = nbits(code); d0 = done_cnt;
    for (int i = 0; i < n; i++) clock_bit(bits[n-1-i], s1, s2);
    if (ackm) begin
      clock_bit(1'b1, s1, s2);
      check("R8 rx ack answer", int'(s2), int'(nack));
    end
    go_low();
    check("R9 R5 one done per frame", done_cnt - d0, 1);
    exp = 8'((init << n) | (bits & 8'((9'd1 << n) - 9'd1)));
    rd(2'd2, v); check("R6 rx data MSB first", v, exp);
  endtask

  initial begin
    logic [7:0] v; logic s1, s2; int d0, lows;
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    rd(2'd0, v); check("R1 control reset", v, 8'h00);
    rd(2'd1, v); check("R1 length reset", v, 8'hF8);
    check("R1 sda released", sda_oe, 0);

    // R3: nonzero length write ignored with SCL high
    scl = 1'b1; wr(2'd1, 8'h05); rd(2'd1, v);
    check("R3 write ignored SCL high", v, 8'hF8);
    go_low(); wr(2'd1, 8'h05); rd(2'd1, v);
    check("R2 R3 upper ones, low write", v, 8'hFD);
    @(negedge clk); scl = 1'b1; wr(2'd1, 8'h00); rd(2'd1, v);
    check("R3 zero write with SCL high", v, 8'hF8);

    // directed frames: full length, one bit, ack and nack
    run_tx(8'hA5, 3'd0, 1'b1, 1'b0);
    run_tx(8'h5C, 3'd1, 1'b0, 1'b0);
    run_tx(8'h3B, 3'd7, 1'b1, 1'b1);
    run_rx(8'hC3, 8'h00, 3'd0, 1'b1, 1'b0);
    run_rx(8'h01, 8'hFF, 3'd1, 1'b1, 1'b1);

    // R10: busy set after first bit, clear after frame
    go_low(); wr(2'd0, 8'h07); wr(2'd1, 8'h03); wr(2'd2, 8'hA0);
    clock_bit(1'b1, s1, s2); rd(2'd0, v); check("R10 busy mid frame", v[5], 1);
    clock_bit(1'b1, s1, s2); clock_bit(1'b1, s1, s2); go_low();
    rd(2'd0, v); check("R10 busy clear at end", v[5], 0);

    // R11: start detect mid frame
    go_low(); wr(2'd0, 8'h03); wr(2'd1, 8'h04); wr(2'd2, 8'hFF);
    clock_bit(1'b1, s1, s2); clock_bit(1'b1, s1, s2);
    @(negedge clk); start_det = 1'b1; @(negedge clk); start_det = 1'b0;
    rd(2'd1, v); check("R11 length cleared", v, 8'hF8);
    rd(2'd0, v); check("R11 busy cleared", v[5], 0);

    // R12: disabled block
    go_low(); wr(2'd0, 8'h02); wr(2'd2, 8'h00); d0 = done_cnt; lows = 0;
    for (int i = 0; i < 9; i++) begin
      clock_bit(1'b1, s1, s2);
      if (!s1 || !s2) lows++;
    end
    go_low();
    check("R12 no drive when off", lows, 0);
    check("R12 no done when off", done_cnt - d0, 0);
    rd(2'd2, v); check("R12 no shift when off", v, 8'h00);

    // random frames
    for (int k = 0; k < 24; k++) begin
      logic [7:0] d; logic [2:0] c; logic am, al;
      d = 8'($urandom); c = 3'($urandom_range(0, 7));
      am = 1'($urandom); al = 1'($urandom);
      if ($urandom_range(0, 1) == 0) run_tx(d, c, am, al);
      else run_rx(d, 8'($urandom), c, am, al);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule